// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Operation-Class Decoder

This block combines a 32-bit arithmetic/logic unit with the small decoder that picks its operation. An instruction pipeline presents two operands, a 2-bit operation class and a 6-bit function field. The decoder turns the class and function field into a 4-bit operation code. The unit then computes the result and a flag that is high when the result is zero.

The 4-bit code is built so that its upper two bits act as operand controls. Bit 2 inverts operand B and sets the carry-in, so subtract is add with a negated B. Bit 3 inverts operand A, and the AND of both inverted operands gives NOR. Set-on-less-than reuses the subtract path and reports a signed comparison in bit 0.

All outputs are registered. A result appears one clock edge after its inputs.

Top module: `alu_unit`

## Requirements
- R1: Operation code 0000 gives the bitwise AND of the operands; it is chosen by class 10 with function field 0x24.
- R2: Operation code 0001 gives the bitwise OR of the operands; it is chosen by class 10 with function field 0x25.
- R3: Operation code 0010 gives A+B modulo 2^32 and ignores carry-out; it is chosen by class 10 with function field 0x20.
- R4: Operation code 0110 gives A-B modulo 2^32; it is chosen by class 10 with function field 0x22.
- R5: Operation code 0111 gives 1 when A is less than B as two's-complement signed numbers, and 0 otherwise. Bits 31..1 are always zero. It is chosen by class 10 with function field 0x2A.
- R6: Operation code 1100 gives the bitwise NOR of the operands; it is chosen by class 10 with function field 0x27.
- R7: Class 11, or class 10 with any other function field, yields operation code 1111, and an undefined code gives a result of zero.
- R8: The zero output is 1 exactly when the registered result equals zero.
- R9: Class 00, used for memory accesses, always yields the add code 0010. Class 01, used for branches, always yields the subtract code 0110. In both cases the function field is ignored.
- R10: The result, zero flag and operation-code outputs are registered: they reflect the inputs sampled at the previous rising clock edge.
- R11: A synchronous active-high reset sets the result to 0, the operation-code output to 0000 and the zero flag to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_class | input | 2 | Operation class: 00 add, 01 subtract, 10 use function field |
| func_code | input | 6 | Function field, decoded when the class is 10 |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| op_q | output | 4 | Registered operation code chosen by the decoder |
| res_q | output | 32 | Registered result |
| zero_q | output | 1 | Registered flag, high when the result is zero |

## Verification
The assertions assume that class, function field and operands are known, non-X values on every rising edge after reset. They also assume that the previous cycle's operands are what the result should reflect.

The bench meets these assumptions as follows:
- It drives every input on the falling edge only.
- It holds the inputs steady across the following rising edge.
- It samples the outputs on the next falling edge.

It also keeps the inputs at legal values during reset, so no checked property sees an undefined input.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [3:0] OP_AND  = 4'b0000;
  localparam logic [3:0] OP_OR   = 4'b0001;
  localparam logic [3:0] OP_ADD  = 4'b0010;
  localparam logic [3:0] OP_SUB  = 4'b0110;
  localparam logic [3:0] OP_SLT  = 4'b0111;
  localparam logic [3:0] OP_NOR  = 4'b1100;
  localparam logic [3:0] OP_NONE = 4'b1111;

  localparam logic [1:0] CLS_MEM  = 2'b00;
  localparam logic [1:0] CLS_BRA  = 2'b01;
  localparam logic [1:0] CLS_FUNC = 2'b10;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/alu_ctrl_dec.sv
module alu_ctrl_dec
  import alu_pkg::*;
#(
  parameter int FUNC_W = 6
) (
  input  logic [1:0]        op_class,
  input  logic [FUNC_W-1:0] func_code,
  output logic [3:0]        op_code
);
  logic [3:0] fn_op;

  // Function-field map for the register-format class
  always_comb begin
    case (func_code)
      FUNC_W'(FN_ADD): fn_op = OP_ADD;
      FUNC_W'(FN_SUB): fn_op = OP_SUB;
      FUNC_W'(FN_AND): fn_op = OP_AND;
      FUNC_W'(FN_OR):  fn_op = OP_OR;
      FUNC_W'(FN_NOR): fn_op = OP_NOR;
      FUNC_W'(FN_SLT): fn_op = OP_SLT;
      default:         fn_op = OP_NONE;
    endcase
  end

  always_comb begin
    case (op_class)
      CLS_MEM:  op_code = OP_ADD;
      CLS_BRA:  op_code = OP_SUB;
      CLS_FUNC: op_code = fn_op;
      default:  op_code = OP_NONE;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_code,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic         inv_a, inv_b;
  logic [W-1:0] a_m, b_m, sum, land, lor;
  logic         ovf, less;

  assign inv_a = op_code[3];
  assign inv_b = op_code[2];
  assign a_m   = inv_a ? ~a : a;
  assign b_m   = inv_b ? ~b : b;

  // Carry-in equals the B-invert bit, so subtract is add of the negated B
  assign sum = a_m + b_m + W'(inv_b);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign land[i] = a_m[i] & b_m[i];
      assign lor[i]  = a_m[i] | b_m[i];
    end
  endgenerate

  // Signed less-than from the sign of the difference, corrected for overflow
  assign ovf  = (a_m[W-1] == b_m[W-1]) && (sum[W-1] != a_m[W-1]);
  assign less = sum[W-1] ^ ovf;

  always_comb begin
    case (op_code)
      OP_AND:  y = land;
      OP_OR:   y = lor;
      OP_ADD:  y = sum;
      OP_SUB:  y = sum;
      OP_SLT:  y = {{(W-1){1'b0}}, less};
      OP_NOR:  y = land;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int FUNC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_class,
  input  logic [FUNC_W-1:0] func_code,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  output logic [3:0]        op_q,
  output logic [W-1:0]      res_q,
  output logic              zero_q
);
  logic [3:0]   op_d;
  logic [W-1:0] res_d;

  alu_ctrl_dec #(.FUNC_W(FUNC_W)) u_dec (
    .op_class (op_class),
    .func_code(func_code),
    .op_code  (op_d)
  );

  alu_core #(.W(W)) u_core (
    .op_code(op_d),
    .a      (opnd_a),
    .b      (opnd_b),
    .y      (res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_AND;
      res_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      op_q   <= op_d;
      res_q  <= res_d;
      zero_q <= ~|res_d;
    end
  end
endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk
  import alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int FUNC_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        op_class,
  input logic [FUNC_W-1:0] func_code,
  input logic [W-1:0]      opnd_a,
  input logic [W-1:0]      opnd_b,
  input logic [3:0]        op_q,
  input logic [W-1:0]      res_q,
  input logic              zero_q
);
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    zero_q == (res_q == '0));

  a_r9_mem_add: assert property (@(posedge clk) disable iff (rst)
    (op_class == CLS_MEM) |=> (op_q == OP_ADD));

  a_r9_branch_sub: assert property (@(posedge clk) disable iff (rst)
    (op_class == CLS_BRA) |=> (op_q == OP_SUB));

  a_r3_add_value: assert property (@(posedge clk) disable iff (rst)
    (op_class == CLS_MEM) |=> (res_q == $past(opnd_a + opnd_b)));

  a_r5_slt_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_SLT) |-> (res_q[W-1:1] == '0));

  a_r7_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_NONE) |-> (res_q == '0));
endmodule

bind alu_unit alu_unit_chk #(.W(W), .FUNC_W(FUNC_W)) u_chk (.*);

// File: tb/tb_alu_unit.sv
`timescale 1ns/1ps
module tb_alu_unit;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    op_class;
  logic [5:0]    func_code;
  logic [W-1:0]  opnd_a, opnd_b;
  logic [3:0]    op_q;
  logic [W-1:0]  res_q;
  logic          zero_q;
  int            checks = 0;
  int            failures = 0;

  always #2.5 clk = ~clk;

  alu_unit dut (
    .clk(clk), .rst(rst), .op_class(op_class), .func_code(func_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_q(op_q), .res_q(res_q), .zero_q(zero_q)
  );

  task automatic chk(input string req, input logic [W-1:0] exp_res,
                     input logic [3:0] exp_op);
    logic exp_z;
    exp_z = (exp_res == '0);
    checks++;
    if (res_q !== exp_res || op_q !== exp_op || zero_q !== exp_z) begin
      failures++;
      $display("FAIL %s: res=%h op=%b zero=%b expected res=%h op=%b zero=%b",
               req, res_q, op_q, zero_q, exp_res, exp_op, exp_z);
    end
  endtask

  // Drive on the falling edge, let one rising edge capture, sample on the next fall
  task automatic run(input logic [1:0] c, input logic [5:0] f,
                     input logic [W-1:0] a, input logic [W-1:0] b);
    op_class = c; func_code = f; opnd_a = a; opnd_b = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    run(2'b10, 6'h20, 32'h1234_5678, 32'h1111_1111);
    chk("R11 reset", 32'h0, 4'b0000);
    rst = 1'b0;
  endtask

  task automatic t_logic;
    run(2'b10, 6'h24, 32'hF0F0_1234, 32'hFF00_0F0F);
    chk("R1 and", 32'hF000_0204, 4'b0000);
    run(2'b10, 6'h24, 32'hAAAA_AAAA, 32'h5555_5555);
    chk("R1 and disjoint", 32'h0, 4'b0000);
    run(2'b10, 6'h25, 32'hF0F0_0000, 32'h0000_1234);
    chk("R2 or", 32'hF0F0_1234, 4'b0001);
    run(2'b10, 6'h27, 32'hF0F0_0000, 32'h0000_1234);
    chk("R6 nor", 32'h0F0F_EDCB, 4'b1100);
    run(2'b10, 6'h27, 32'h0, 32'h0);
    chk("R6 nor of zeros", 32'hFFFF_FFFF, 4'b1100);
  endtask

  task automatic t_arith;
    run(2'b10, 6'h20, 32'd1000, 32'd234);
    chk("R3 add", 32'd1234, 4'b0010);
    run(2'b10, 6'h20, 32'hFFFF_FFFF, 32'h1);
    chk("R3 add wrap R8 zero", 32'h0, 4'b0010);
    run(2'b10, 6'h22, 32'd10, 32'd3);
    chk("R4 sub", 32'd7, 4'b0110);
    run(2'b10, 6'h22, 32'd3, 32'd10);
    chk("R4 sub negative", 32'hFFFF_FFF9, 4'b0110);
  endtask

  task automatic t_slt;
    run(2'b10, 6'h2A, 32'hFFFF_FFFF, 32'h1);
    chk("R5 slt neg<pos", 32'h1, 4'b0111);
    run(2'b10, 6'h2A, 32'h1, 32'hFFFF_FFFF);
    chk("R5 slt pos>neg", 32'h0, 4'b0111);
    run(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF);
    chk("R5 slt min<max", 32'h1, 4'b0111);
    run(2'b10, 6'h2A, 32'd55, 32'd55);
    chk("R5 slt equal", 32'h0, 4'b0111);
  endtask

  task automatic t_class;
    run(2'b00, 6'h24, 32'd400, 32'd20);
    chk("R9 memory class adds", 32'd420, 4'b0010);
    run(2'b01, 6'h25, 32'd400, 32'd20);
    chk("R9 branch class subtracts", 32'd380, 4'b0110);
    run(2'b01, 6'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    chk("R9 branch equal R8 zero", 32'h0, 4'b0110);
    run(2'b11, 6'h20, 32'd5, 32'd6);
    chk("R7 class 11 undefined", 32'h0, 4'b1111);
    run(2'b10, 6'h21, 32'd5, 32'd6);
    chk("R7 unknown function", 32'h0, 4'b1111);
  endtask

  task automatic t_latency;
    // R10: output holds the previous cycle's inputs until the next edge
    op_class = 2'b00; func_code = 6'h0; opnd_a = 32'd7; opnd_b = 32'd8;
    @(posedge clk); #1;
    opnd_a = 32'd100;
    #1;
    checks++;
    if (res_q !== 32'd15) begin
      failures++;
      $display("FAIL R10 registered output: res=%h expected res=%h", res_q, 32'd15);
    end
    @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R10 next edge", 32'd108, 4'b0010);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    op_class = 2'b00; func_code = 6'h0; opnd_a = '0; opnd_b = '0;
    @(negedge clk);
    t_reset();
    t_logic();
    t_arith();
    t_slt();
    t_class();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule